// File: doc/BRIEF.md
# Load Ordering Violation Queue

This block is a circular queue that tracks every load in flight between dispatch and commit and finds loads that read memory too early. Loads take an entry in program order at dispatch and receive a sequence number. They fill in their address on one of several address-write ports once it is computed, and leave the queue in order at commit. A load counts as executed once its address has been written.

Two sources search the stored addresses associatively. A store whose address has just been computed catches loads that ran ahead of it within the same thread. An external invalidate catches loads whose value may have been changed by another agent. When either search matches, the block raises a squash one cycle later. The squash carries the sequence number of the oldest offending load and says which source caught it. The pipeline is expected to flush from that load onward and to roll the queue tail back to it.

Top module: `ldq_order_guard`

## Requirements
- R1: After reset the queue is empty (`lq_empty`=1, `lq_full`=0), `alloc_seq` is 0 and `squash_valid` is 0.
- R2: Each cycle with `alloc_valid`=1, no rollback and a queue that is not full, the load gets `alloc_seq` and `alloc_seq` then advances by one modulo 2*DEPTH. After DEPTH live loads `lq_full` is 1, and further allocation requests leave `alloc_seq` unchanged.
- R3: `commit_valid` frees the oldest live entry, and a freed load no longer matches any search. A commit on an empty queue has no effect on the head of the queue.
- R4: A store search (`st_valid`) raises `squash_valid` in the next cycle when some live, executed load has the same word address (address bits above bit 1) and a sequence number that is not older than `st_seq`. "Not older" means the top bit of (load sequence − `st_seq`) taken modulo 2*DEPTH is 0, so a load whose sequence number equals `st_seq` counts as younger.
- R5: A store search does not flag loads that are older than the store, loads that have not executed, or loads whose word address differs.
- R6: A snoop (`snp_valid`) raises `squash_valid` in the next cycle when some live, executed load lies in the same 64-byte line (address bits 31..6), whatever its age.
- R7: A snoop does not flag loads that have not executed (including a slot that has been re-allocated since its address was written) or loads in other lines.
- R8: When several loads match, in one search or across both searches in the same cycle, `squash_seq` is the sequence number of the match closest to the head of the queue.
- R9: `squash_cause` bit 0 is set when the reported load matched the store search, and bit 1 when it matched the snoop. Whenever `squash_valid` is 1, at least one of the two bits is set.
- R10: `rb_valid` sets the tail to `rb_seq` and takes priority over allocation. Entries at and beyond `rb_seq` are discarded: they no longer match, and `alloc_seq` equals `rb_seq` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Dispatch one load this cycle |
| alloc_seq | output | SEQ_W | Sequence number the next allocated load receives |
| lq_full | output | 1 | All DEPTH entries are live |
| lq_empty | output | 1 | No entry is live |
| wr_valid | input | WR_PORTS | Address-write strobe, one bit per port |
| wr_seq | input | WR_PORTS*SEQ_W | Sequence number of the load being written, per port |
| wr_addr | input | WR_PORTS*ADDR_W | Computed load address, per port |
| commit_valid | input | 1 | Retire the oldest load |
| st_valid | input | 1 | Store address search this cycle |
| st_seq | input | SEQ_W | Sequence number of the first load dispatched after the store |
| st_addr | input | ADDR_W | Store address |
| snp_valid | input | 1 | External invalidate search this cycle |
| snp_addr | input | ADDR_W | Invalidate address |
| rb_valid | input | 1 | Roll the tail back |
| rb_seq | input | SEQ_W | New tail sequence number |
| squash_valid | output | 1 | A violation was found in the previous cycle |
| squash_seq | output | SEQ_W | Sequence number of the oldest offending load |
| squash_cause | output | 2 | Bit 0: store match, bit 1: snoop match |

## Verification
A fixed population of eight loads is searched with a table of store, snoop and combined requests. The population includes an unexecuted load, repeated word addresses, and neighbouring words in one line. These patterns separate word-granular from line-granular matching, age-qualified store matches from age-free snoop matches, and the oldest-match choice across both sources. Directed sequences then exercise commit, rollback, re-allocation of a previously executed slot, full and empty limits, and a store search across the sequence-number wrap, where a plain magnitude compare would give the wrong order.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

    localparam int unsigned DEF_DEPTH    = 32;
    localparam int unsigned DEF_ADDR_W   = 32;
    localparam int unsigned DEF_WR_PORTS = 2;
    localparam int unsigned DEF_LINE_OFF = 6;
    localparam int unsigned DEF_WORD_OFF = 2;

    // Which search caught the reported load.
    typedef struct packed {
        logic snoop;
        logic store;
    } hit_cause_t;

    // A sequence difference taken modulo 2^w lies in the forward window
    // when its top bit is clear.
    function automatic logic seq_in_window(input logic [31:0] delta,
                                           input int unsigned w);
        return !delta[w-1];
    endfunction

endpackage

// File: rtl/ldq_ring_ctrl.sv
module ldq_ring_ctrl #(
    parameter int unsigned DEPTH = ldq_pkg::DEF_DEPTH,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned SEQ_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_req,
    input  logic             commit_req,
    input  logic             rb_req,
    input  logic [SEQ_W-1:0] rb_seq,
    output logic [SEQ_W-1:0] head_seq,
    output logic [SEQ_W-1:0] tail_seq,
    output logic             full,
    output logic             empty,
    output logic             alloc_fire,
    output logic [DEPTH-1:0] live_vec
);

    logic [SEQ_W-1:0] head_q, tail_q, count;
    logic             commit_fire;

    assign count       = tail_q - head_q;
    assign full        = (count == SEQ_W'(DEPTH));
    assign empty       = (count == '0);
    assign alloc_fire  = alloc_req && !full && !rb_req;
    assign commit_fire = commit_req && !empty;
    assign head_seq    = head_q;
    assign tail_seq    = tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (commit_fire)
                head_q <= head_q + SEQ_W'(1);
            if (rb_req)
                tail_q <= rb_seq;
            else if (alloc_fire)
                tail_q <= tail_q + SEQ_W'(1);
        end
    end

    // An entry is live when its distance from the head is below the count.
    for (genvar i = 0; i < DEPTH; i++) begin : g_live
        logic [IDX_W-1:0] off;
        assign off         = IDX_W'(i) - head_q[IDX_W-1:0];
        assign live_vec[i] = ({1'b0, off} < count);
    end

endmodule

// File: rtl/ldq_entry_store.sv
module ldq_entry_store #(
    parameter int unsigned DEPTH    = ldq_pkg::DEF_DEPTH,
    parameter int unsigned ADDR_W   = ldq_pkg::DEF_ADDR_W,
    parameter int unsigned WR_PORTS = ldq_pkg::DEF_WR_PORTS,
    parameter int unsigned LINE_OFF = ldq_pkg::DEF_LINE_OFF,
    parameter int unsigned WORD_OFF = ldq_pkg::DEF_WORD_OFF,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned SEQ_W = IDX_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [DEPTH-1:0]           live_vec,
    input  logic                       alloc_fire,
    input  logic [SEQ_W-1:0]           alloc_seq,
    input  logic [WR_PORTS-1:0]        wr_valid,
    input  logic [WR_PORTS*SEQ_W-1:0]  wr_seq,
    input  logic [WR_PORTS*ADDR_W-1:0] wr_addr,
    input  logic                       st_valid,
    input  logic [SEQ_W-1:0]           st_seq,
    input  logic [ADDR_W-1:0]          st_addr,
    input  logic                       snp_valid,
    input  logic [ADDR_W-1:0]          snp_addr,
    output logic [DEPTH-1:0]           st_hit,
    output logic [DEPTH-1:0]           snp_hit
);

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        // Address column (searched) and metadata column (age, executed).
        logic [ADDR_W-1:0] addr_r;
        logic [SEQ_W-1:0]  seq_r;
        logic              done_r;
        logic              wr_sel;
        logic [ADDR_W-1:0] wr_data;
        logic              take_alloc;
        logic [SEQ_W-1:0]  delta;
        logic              word_eq, line_eq;

        // Higher-numbered write port wins if two target one entry.
        always_comb begin
            wr_sel  = 1'b0;
            wr_data = addr_r;
            for (int p = 0; p < WR_PORTS; p++) begin
                if (wr_valid[p] && (wr_seq[p*SEQ_W +: IDX_W] == IDX_W'(e))) begin
                    wr_sel  = 1'b1;
                    wr_data = wr_addr[p*ADDR_W +: ADDR_W];
                end
            end
        end

        assign take_alloc = alloc_fire && (alloc_seq[IDX_W-1:0] == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                addr_r <= '0;
                seq_r  <= '0;
                done_r <= 1'b0;
            end else if (take_alloc) begin
                seq_r  <= alloc_seq;
                done_r <= 1'b0;
            end else if (wr_sel && live_vec[e]) begin
                addr_r <= wr_data;
                done_r <= 1'b1;
            end
        end

        assign delta   = seq_r - st_seq;
        assign word_eq = (addr_r[ADDR_W-1:WORD_OFF] == st_addr[ADDR_W-1:WORD_OFF]);
        assign line_eq = (addr_r[ADDR_W-1:LINE_OFF] == snp_addr[ADDR_W-1:LINE_OFF]);

        assign st_hit[e]  = st_valid && live_vec[e] && done_r && word_eq &&
                            ldq_pkg::seq_in_window(32'(delta), SEQ_W);
        assign snp_hit[e] = snp_valid && live_vec[e] && done_r && line_eq;
    end

endmodule

// File: rtl/ldq_oldest_sel.sv
module ldq_oldest_sel #(
    parameter int unsigned DEPTH = ldq_pkg::DEF_DEPTH,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned SEQ_W = IDX_W + 1
) (
    input  logic [DEPTH-1:0]         st_hit,
    input  logic [DEPTH-1:0]         snp_hit,
    input  logic [SEQ_W-1:0]         head_seq,
    output logic                     found,
    output logic [SEQ_W-1:0]         pick_seq,
    output ldq_pkg::hit_cause_t      pick_cause
);

    logic [IDX_W-1:0] idx;

    // Walk outward from the head; the first match is the oldest load.
    always_comb begin
        found      = 1'b0;
        pick_seq   = head_seq;
        pick_cause = '0;
        idx        = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_seq[IDX_W-1:0] + IDX_W'(k);
            if (!found && (st_hit[idx] || snp_hit[idx])) begin
                found            = 1'b1;
                pick_seq         = head_seq + SEQ_W'(k);
                pick_cause.store = st_hit[idx];
                pick_cause.snoop = snp_hit[idx];
            end
        end
    end

endmodule

// File: rtl/ldq_order_guard.sv
module ldq_order_guard #(
    parameter int unsigned DEPTH    = ldq_pkg::DEF_DEPTH,
    parameter int unsigned ADDR_W   = ldq_pkg::DEF_ADDR_W,
    parameter int unsigned WR_PORTS = ldq_pkg::DEF_WR_PORTS,
    parameter int unsigned LINE_OFF = ldq_pkg::DEF_LINE_OFF,
    parameter int unsigned WORD_OFF = ldq_pkg::DEF_WORD_OFF,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned SEQ_W = IDX_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc_valid,
    output logic [SEQ_W-1:0]           alloc_seq,
    output logic                       lq_full,
    output logic                       lq_empty,
    input  logic [WR_PORTS-1:0]        wr_valid,
    input  logic [WR_PORTS*SEQ_W-1:0]  wr_seq,
    input  logic [WR_PORTS*ADDR_W-1:0] wr_addr,
    input  logic                       commit_valid,
    input  logic                       st_valid,
    input  logic [SEQ_W-1:0]           st_seq,
    input  logic [ADDR_W-1:0]          st_addr,
    input  logic                       snp_valid,
    input  logic [ADDR_W-1:0]          snp_addr,
    input  logic                       rb_valid,
    input  logic [SEQ_W-1:0]           rb_seq,
    output logic                       squash_valid,
    output logic [SEQ_W-1:0]           squash_seq,
    output logic [1:0]                 squash_cause
);

    logic [SEQ_W-1:0]    head_seq, tail_seq;
    logic                alloc_fire;
    logic [DEPTH-1:0]    live_vec, st_hit, snp_hit;
    logic                found;
    logic [SEQ_W-1:0]    pick_seq;
    ldq_pkg::hit_cause_t pick_cause;

    ldq_ring_ctrl #(.DEPTH(DEPTH)) ring_i (
        .clk        (clk),
        .rst        (rst),
        .alloc_req  (alloc_valid),
        .commit_req (commit_valid),
        .rb_req     (rb_valid),
        .rb_seq     (rb_seq),
        .head_seq   (head_seq),
        .tail_seq   (tail_seq),
        .full       (lq_full),
        .empty      (lq_empty),
        .alloc_fire (alloc_fire),
        .live_vec   (live_vec)
    );

    assign alloc_seq = tail_seq;

    ldq_entry_store #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .WR_PORTS(WR_PORTS),
        .LINE_OFF(LINE_OFF), .WORD_OFF(WORD_OFF)
    ) ent_i (
        .clk        (clk),
        .rst        (rst),
        .live_vec   (live_vec),
        .alloc_fire (alloc_fire),
        .alloc_seq  (tail_seq),
        .wr_valid   (wr_valid),
        .wr_seq     (wr_seq),
        .wr_addr    (wr_addr),
        .st_valid   (st_valid),
        .st_seq     (st_seq),
        .st_addr    (st_addr),
        .snp_valid  (snp_valid),
        .snp_addr   (snp_addr),
        .st_hit     (st_hit),
        .snp_hit    (snp_hit)
    );

    ldq_oldest_sel #(.DEPTH(DEPTH)) sel_i (
        .st_hit     (st_hit),
        .snp_hit    (snp_hit),
        .head_seq   (head_seq),
        .found      (found),
        .pick_seq   (pick_seq),
        .pick_cause (pick_cause)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            squash_valid <= 1'b0;
            squash_seq   <= '0;
            squash_cause <= '0;
        end else begin
            squash_valid <= found;
            squash_seq   <= pick_seq;
            squash_cause <= pick_cause;
        end
    end

endmodule

// File: rtl/ldq_order_guard_chk.sv
module ldq_order_guard_chk #(
    parameter int unsigned DEPTH = ldq_pkg::DEF_DEPTH,
    localparam int unsigned SEQ_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_valid,
    input logic [SEQ_W-1:0] alloc_seq,
    input logic             lq_full,
    input logic             lq_empty,
    input logic             commit_valid,
    input logic             rb_valid,
    input logic [SEQ_W-1:0] rb_seq,
    input logic             squash_valid,
    input logic [1:0]       squash_cause
);

    // R1
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lq_full && lq_empty));

    // R2
    alloc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !lq_full && !rb_valid) |=> (alloc_seq == $past(alloc_seq) + SEQ_W'(1)));

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && lq_full && !rb_valid) |=> (alloc_seq == $past(alloc_seq)));

    // R3
    empty_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (lq_empty && commit_valid && !alloc_valid && !rb_valid) |=> lq_empty);

    // R5
    quiet_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        lq_empty |=> !squash_valid);

    // R9
    cause_present_chk: assert property (@(posedge clk) disable iff (rst)
        squash_valid |-> (squash_cause != 2'b00));

    // R10
    rollback_tail_chk: assert property (@(posedge clk) disable iff (rst)
        rb_valid |=> (alloc_seq == $past(rb_seq)));

endmodule

bind ldq_order_guard ldq_order_guard_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/ldq_order_guard_tb_top.sv
`timescale 1ns/1ps
module ldq_order_guard_tb_top;

    localparam int unsigned DEPTH = 32;
    localparam int unsigned AW    = 32;
    localparam int unsigned SW    = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          alloc_valid;
    logic [SW-1:0] alloc_seq;
    logic          lq_full, lq_empty;
    logic [1:0]    wr_valid;
    logic [2*SW-1:0] wr_seq;
    logic [2*AW-1:0] wr_addr;
    logic          commit_valid;
    logic          st_valid;
    logic [SW-1:0] st_seq;
    logic [AW-1:0] st_addr;
    logic          snp_valid;
    logic [AW-1:0] snp_addr;
    logic          rb_valid;
    logic [SW-1:0] rb_seq;
    logic          squash_valid;
    logic [SW-1:0] squash_seq;
    logic [1:0]    squash_cause;

    always #2.5 clk = ~clk;

    ldq_order_guard dut_i (.*);

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic          sv;
        logic [5:0]    sseq;
        logic [31:0]   saddr;
        logic          nv;
        logic [31:0]   naddr;
        logic          ev;
        logic [5:0]    eseq;
        logic [1:0]    ecause;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'd0, 32'h1000, 1'b0, 32'h0,    1'b1, 6'd0, 2'b01},
        '{1'b1, 6'd1, 32'h1000, 1'b0, 32'h0,    1'b1, 6'd3, 2'b01},
        '{1'b1, 6'd4, 32'h1000, 1'b0, 32'h0,    1'b1, 6'd6, 2'b01},
        '{1'b1, 6'd7, 32'h1000, 1'b0, 32'h0,    1'b0, 6'd0, 2'b00},
        '{1'b1, 6'd0, 32'h1002, 1'b0, 32'h0,    1'b1, 6'd0, 2'b01},
        '{1'b1, 6'd0, 32'h100C, 1'b0, 32'h0,    1'b0, 6'd0, 2'b00},
        '{1'b1, 6'd0, 32'h2000, 1'b0, 32'h0,    1'b1, 6'd7, 2'b01},
        '{1'b1, 6'd3, 32'h2000, 1'b0, 32'h0,    1'b1, 6'd7, 2'b01},
        '{1'b0, 6'd0, 32'h0,    1'b1, 32'h1010, 1'b1, 6'd0, 2'b10},
        '{1'b0, 6'd0, 32'h0,    1'b1, 32'h2020, 1'b1, 6'd7, 2'b10},
        '{1'b0, 6'd0, 32'h0,    1'b1, 32'h4000, 1'b0, 6'd0, 2'b00},
        '{1'b1, 6'd5, 32'h3000, 1'b1, 32'h2000, 1'b1, 6'd5, 2'b01},
        '{1'b1, 6'd3, 32'h1000, 1'b1, 32'h1000, 1'b1, 6'd0, 2'b10},
        '{1'b1, 6'd0, 32'h1000, 1'b1, 32'h1030, 1'b1, 6'd0, 2'b11},
        '{1'b1, 6'd6, 32'h1000, 1'b0, 32'h0,    1'b1, 6'd6, 2'b01}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; wr_valid = '0; commit_valid = 0;
        st_valid = 0; snp_valid = 0; rb_valid = 0;
    endtask

    task automatic cycle();
        @(negedge clk);
        idle();
    endtask

    task automatic alloc_n(input int n);
        for (int i = 0; i < n; i++) begin
            alloc_valid = 1;
            cycle();
        end
    endtask

    task automatic commit_n(input int n);
        for (int i = 0; i < n; i++) begin
            commit_valid = 1;
            cycle();
        end
    endtask

    task automatic write2(input logic v0, input logic [5:0] s0, input logic [31:0] a0,
                          input logic v1, input logic [5:0] s1, input logic [31:0] a1);
        wr_valid = {v1, v0};
        wr_seq   = {s1, s0};
        wr_addr  = {a1, a0};
        cycle();
    endtask

    task automatic search(input logic sv, input logic [5:0] ss, input logic [31:0] sa,
                          input logic nv, input logic [31:0] na);
        st_valid = sv; st_seq = ss; st_addr = sa;
        snp_valid = nv; snp_addr = na;
        cycle();
    endtask

    task automatic expect_sq(input string tag, input logic ev, input logic [5:0] es,
                             input logic [1:0] ec);
        chk(tag, 32'(squash_valid), 32'(ev));
        if (ev) begin
            chk(tag, 32'(squash_seq), 32'(es));
            chk({tag, "/R9"}, 32'(squash_cause), 32'(ec));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        wr_seq = '0; wr_addr = '0; st_seq = '0; st_addr = '0;
        snp_addr = '0; rb_seq = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 empty", 32'(lq_empty), 1);
        chk("R1 full", 32'(lq_full), 0);
        chk("R1 alloc_seq", 32'(alloc_seq), 0);
        chk("R1 squash", 32'(squash_valid), 0);

        // Population: seq0..7; seq2 never executes.
        alloc_n(8);
        chk("R2 alloc_seq after 8", 32'(alloc_seq), 8);
        write2(1, 6'd0, 32'h1000, 1, 6'd1, 32'h1004);
        write2(1, 6'd3, 32'h1000, 1, 6'd4, 32'h1008);
        write2(1, 6'd5, 32'h3000, 1, 6'd6, 32'h1000);
        write2(1, 6'd7, 32'h2000, 0, 6'd0, 32'h0);

        // Table of searches: R4/R5 store, R6/R7 snoop, R8 both
        for (int v = 0; v < NV; v++) begin
            string tag;
            if (!VECS[v].ev)                    tag = VECS[v].sv ? "R5" : "R7";
            else if (VECS[v].sv && VECS[v].nv)  tag = "R8";
            else                                tag = VECS[v].sv ? "R4" : "R6";
            tag = $sformatf("%s vec%0d", tag, v);
            search(VECS[v].sv, VECS[v].sseq, VECS[v].saddr, VECS[v].nv, VECS[v].naddr);
            expect_sq(tag, VECS[v].ev, VECS[v].eseq, VECS[v].ecause);
        end

        // R3: committed loads stop matching
        commit_n(2);
        search(0, 6'd0, 32'h0, 1, 32'h1000);
        expect_sq("R3 commit", 1, 6'd3, 2'b10);

        // R10: rollback discards seq5..7
        rb_valid = 1; rb_seq = 6'd5;
        cycle();
        chk("R10 tail", 32'(alloc_seq), 5);
        search(0, 6'd0, 32'h0, 1, 32'h3000);
        expect_sq("R10 discarded", 0, 6'd0, 2'b00);
        search(1, 6'd3, 32'h1000, 0, 32'h0);
        expect_sq("R10 kept", 1, 6'd3, 2'b01);

        // R7: re-allocated slot is not executed
        alloc_n(1);
        chk("R2 realloc seq", 32'(alloc_seq), 6);
        search(0, 6'd0, 32'h0, 1, 32'h3000);
        expect_sq("R7 realloc", 0, 6'd0, 2'b00);
        search(1, 6'd5, 32'h3000, 0, 32'h0);
        expect_sq("R5 unexec", 0, 6'd0, 2'b00);

        // R2: fill to full, extra request ignored
        alloc_n(28);
        chk("R2 full", 32'(lq_full), 1);
        chk("R2 seq at full", 32'(alloc_seq), 34);
        alloc_n(1);
        chk("R2 full hold", 32'(alloc_seq), 34);

        // R3: drain, then a commit on an empty queue is ignored
        commit_n(32);
        chk("R3 empty", 32'(lq_empty), 1);
        commit_n(1);
        chk("R3 still empty", 32'(lq_empty), 1);
        alloc_n(32);
        chk("R3 head kept", 32'(lq_full), 1);
        chk("R2 wrap seq", 32'(alloc_seq), 2);

        // R4/R8 across the sequence wrap: live seq 34..63,0,1
        write2(1, 6'd62, 32'h5000, 1, 6'd1, 32'h5000);
        search(1, 6'd63, 32'h5000, 0, 32'h0);
        expect_sq("R4 wrap younger", 1, 6'd1, 2'b01);
        search(1, 6'd60, 32'h5000, 0, 32'h0);
        expect_sq("R8 wrap oldest", 1, 6'd62, 2'b01);
        search(0, 6'd0, 32'h0, 1, 32'h5004);
        expect_sq("R6 wrap snoop", 1, 6'd62, 2'b10);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule